// File: doc/BRIEF.md
# Serial EEPROM Page-Write Controller

This block is the slave-side engine for the write instruction of a byte-serial EEPROM. A bit-level front end, not part of this block, hands it one received byte at a time. Each byte comes with a valid strobe and a master-acknowledge flag that tells whether another byte follows. A separate input reports a standby pulse on the line. The controller checks the framing bytes and latches a 16-bit word address. It then gathers data bytes into a page buffer. When the master signals the last byte, it commits the buffer to a small on-chip byte array during a timed write cycle.

A write is honoured only after a write-enable command has armed an enable latch. Data bytes stay inside one page. Only the low pointer bits advance, so a transfer that runs past the page end wraps to the page start and replaces bytes already buffered there. A standby pulse or an early end-of-data aborts the transfer with no write. An observation read port exposes the array contents.

Top module: `eepw_pgwr_ctrl`

## Requirements
- R1: After reset, busy and the enable latch are 0 and every array byte reads 0x00.
- R2: The byte sequence 0x55, device address, 0x96 sets the enable latch (`wel` = 1).
- R3: A write sequence received while the enable latch is 0 is ignored: busy never rises and the array is unchanged.
- R4: A write is 0x55, device address, 0x6C, address high byte, address low byte, then data bytes. The first data byte lands at the given word address. The array index is the word address modulo MEM_DEPTH.
- R5: After each data byte only the low log2(PAGE_BYTES) address bits increment. Bytes past the page end wrap to the page start and overwrite earlier bytes of the same transfer.
- R6: A data byte with `byte_mak` = 0 ends the transfer. `busy` rises on the next clock and stays high for exactly TWC_CYCLES cycles. The array shows the new data once busy falls.
- R7: Only the page positions that received data in the transfer are written. Other array bytes keep their values.
- R8: `byte_mak` = 0 on the device address, write command, or either address byte aborts the transfer with no write cycle.
- R9: A standby pulse before the terminating data byte aborts the transfer. Nothing is written, and bytes buffered so far are discarded.
- R10: A header byte other than 0x55, a device byte other than DEV_ADDR, or an unknown command returns the controller to idle with the array unchanged.
- R11: While busy, received bytes and standby pulses are ignored. A write-enable command sent then does not set the latch, and the commit still completes.
- R12: The enable latch clears when a write cycle completes.
- R13: The expected device address is the parameter DEV_ADDR. Any other value, including one differing only in bit 0, is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_vld | input | 1 | One-cycle strobe: a received byte is present |
| byte_data | input | 8 | Received byte |
| byte_mak | input | 1 | 1 = master acknowledge (more follows), 0 = no acknowledge |
| standby | input | 1 | Standby pulse seen on the line |
| rd_addr | input | 16 | Observation read address |
| rd_data | output | 8 | Array byte at rd_addr (combinational) |
| busy | output | 1 | Internal write cycle in progress |
| wel | output | 1 | Write-enable latch |

## Verification
The bench builds the block with DEV_ADDR = 0xA1, so the default 0xA0 becomes a bit-0-only mismatch that must be rejected. TWC_CYCLES = 12 makes the exact busy length cheap to measure and leaves room to inject a full write-enable command and a standby pulse inside one write cycle. PAGE_BYTES = 16 with MEM_DEPTH = 64 gives four pages. This makes the page wrap at 0x3C, a 20-byte overrun that overwrites buffered slots, and address aliasing from a high word address all reachable.

// File: rtl/eepw_pkg.sv
package eepw_pkg;

  localparam int unsigned WORD_AW = 16;

  localparam logic [7:0] HDR_BYTE  = 8'h55;
  localparam logic [7:0] CMD_WRITE = 8'h6C;
  localparam logic [7:0] CMD_WREN  = 8'h96;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_CMD,
    ST_AHI,
    ST_ALO,
    ST_DATA,
    ST_BUSY
  } seq_state_t;

  // low slot_bits of the word address form the in-page offset
  function automatic logic [WORD_AW-1:0] slot_mask(input int unsigned slot_bits);
    return WORD_AW'((32'd1 << slot_bits) - 32'd1);
  endfunction

  // next pointer: offset wraps inside the page, page bits untouched
  function automatic logic [WORD_AW-1:0] ptr_advance(input logic [WORD_AW-1:0] a,
                                                     input int unsigned slot_bits);
    logic [WORD_AW-1:0] m;
    m = slot_mask(slot_bits);
    return (a & ~m) | ((a + WORD_AW'(1)) & m);
  endfunction

  // word address of page slot s within the page holding a
  function automatic logic [WORD_AW-1:0] slot_addr(input logic [WORD_AW-1:0] a,
                                                   input int unsigned s,
                                                   input int unsigned slot_bits);
    logic [WORD_AW-1:0] m;
    m = slot_mask(slot_bits);
    return (a & ~m) | (WORD_AW'(s) & m);
  endfunction

endpackage

// File: rtl/eepw_seq.sv
module eepw_seq
  import eepw_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR = 8'hA0,
  parameter int unsigned SLOT_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               byte_vld,
  input  logic [7:0]         byte_data,
  input  logic               byte_mak,
  input  logic               standby,
  input  logic               done,
  input  logic               wel,
  output logic               wel_set,
  output logic               commit_evt,
  output logic               abort_evt,
  output logic               reject_evt,
  output logic               data_evt,
  output logic               buf_clear,
  output logic [SLOT_W-1:0]  slot,
  output logic [WORD_AW-1:0] word_addr
);

  seq_state_t         st_q, st_d;
  logic [WORD_AW-1:0] addr_q;
  logic               load_hi, load_lo;

  always_comb begin
    st_d       = st_q;
    wel_set    = 1'b0;
    commit_evt = 1'b0;
    abort_evt  = 1'b0;
    reject_evt = 1'b0;
    data_evt   = 1'b0;
    buf_clear  = 1'b0;
    load_hi    = 1'b0;
    load_lo    = 1'b0;
    if (st_q == ST_BUSY) begin
      if (done) st_d = ST_IDLE;
    end else if (standby && st_q != ST_IDLE) begin
      abort_evt = 1'b1;
      st_d      = ST_IDLE;
    end else if (byte_vld) begin
      case (st_q)
        ST_IDLE: begin
          if (byte_data == HDR_BYTE) st_d = ST_DEV;
        end
        ST_DEV: begin
          if (byte_data != DEV_ADDR) begin
            reject_evt = 1'b1;
            st_d       = ST_IDLE;
          end else if (!byte_mak) begin
            abort_evt = 1'b1;
            st_d      = ST_IDLE;
          end else begin
            st_d = ST_CMD;
          end
        end
        ST_CMD: begin
          if (byte_data == CMD_WREN) begin
            wel_set = 1'b1;
            st_d    = ST_IDLE;
          end else if (byte_data == CMD_WRITE && wel) begin
            if (!byte_mak) begin
              abort_evt = 1'b1;
              st_d      = ST_IDLE;
            end else begin
              st_d = ST_AHI;
            end
          end else begin
            reject_evt = 1'b1;
            st_d       = ST_IDLE;
          end
        end
        ST_AHI: begin
          if (!byte_mak) begin
            abort_evt = 1'b1;
            st_d      = ST_IDLE;
          end else begin
            load_hi = 1'b1;
            st_d    = ST_ALO;
          end
        end
        ST_ALO: begin
          if (!byte_mak) begin
            abort_evt = 1'b1;
            st_d      = ST_IDLE;
          end else begin
            load_lo   = 1'b1;
            buf_clear = 1'b1;
            st_d      = ST_DATA;
          end
        end
        ST_DATA: begin
          data_evt = 1'b1;
          if (!byte_mak) begin
            commit_evt = 1'b1;
            st_d       = ST_BUSY;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
    end else begin
      st_q <= st_d;
      if (load_hi)       addr_q[15:8] <= byte_data;
      else if (load_lo)  addr_q[7:0]  <= byte_data;
      else if (data_evt) addr_q       <= ptr_advance(addr_q, SLOT_W);
    end
  end

  assign slot      = addr_q[SLOT_W-1:0];
  assign word_addr = addr_q;

endmodule

// File: rtl/eepw_pagebuf.sv
module eepw_pagebuf #(
  parameter int unsigned PAGE   = 16,
  parameter int unsigned SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [7:0]        wr_data,
  output logic [PAGE*8-1:0] buf_flat,
  output logic [PAGE-1:0]   mask
);

  for (genvar g = 0; g < PAGE; g++) begin : g_slot
    logic [7:0] byte_q;
    logic       vld_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        byte_q <= '0;
        vld_q  <= 1'b0;
      end else if (wr_en && wr_slot == SLOT_W'(g)) begin
        byte_q <= wr_data;
        vld_q  <= 1'b1;
      end else if (clear) begin
        vld_q <= 1'b0;
      end
    end
    assign buf_flat[g*8 +: 8] = byte_q;
    assign mask[g]            = vld_q;
  end

endmodule

// File: rtl/eepw_wtimer.sv
module eepw_wtimer #(
  parameter int unsigned TWC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int unsigned CNT_W = $clog2(TWC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (start)        cnt_q <= CNT_W'(TWC);
    else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/eepw_array.sv
module eepw_array
  import eepw_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned PAGE   = 16,
  parameter int unsigned SLOT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic [WORD_AW-1:0] page_addr,
  input  logic [PAGE*8-1:0]  buf_flat,
  input  logic [PAGE-1:0]    mask,
  input  logic [WORD_AW-1:0] rd_addr,
  output logic [7:0]         rd_data
);

  localparam int unsigned MEM_AW = $clog2(DEPTH);

  logic [7:0]        mem [DEPTH];
  logic [MEM_AW-1:0] wr_idx [PAGE];

  for (genvar g = 0; g < PAGE; g++) begin : g_idx
    assign wr_idx[g] = MEM_AW'(slot_addr(page_addr, g, SLOT_W));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (commit) begin
      for (int i = 0; i < PAGE; i++) begin
        if (mask[i]) mem[wr_idx[i]] <= buf_flat[i*8 +: 8];
      end
    end
  end

  assign rd_data = mem[MEM_AW'(rd_addr)];

endmodule

// File: rtl/eepw_pgwr_ctrl.sv
module eepw_pgwr_ctrl
  import eepw_pkg::*;
#(
  parameter logic [7:0]  DEV_ADDR   = 8'hA0,
  parameter int unsigned PAGE_BYTES = 16,
  parameter int unsigned MEM_DEPTH  = 64,
  parameter int unsigned TWC_CYCLES = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_vld,
  input  logic [7:0]  byte_data,
  input  logic        byte_mak,
  input  logic        standby,
  input  logic [15:0] rd_addr,
  output logic [7:0]  rd_data,
  output logic        busy,
  output logic        wel
);

  localparam int unsigned SLOT_W = $clog2(PAGE_BYTES);

  // named internal events, also observed by the bound checker
  logic                   wel_set, commit_evt, abort_evt, reject_evt;
  logic                   data_evt, buf_clear, done_evt;
  logic [SLOT_W-1:0]      slot;
  logic [WORD_AW-1:0]     word_addr;
  logic [PAGE_BYTES*8-1:0] buf_flat;
  logic [PAGE_BYTES-1:0]  buf_mask;
  logic                   wel_q;

  eepw_seq #(
    .DEV_ADDR (DEV_ADDR),
    .SLOT_W   (SLOT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_vld   (byte_vld),
    .byte_data  (byte_data),
    .byte_mak   (byte_mak),
    .standby    (standby),
    .done       (done_evt),
    .wel        (wel_q),
    .wel_set    (wel_set),
    .commit_evt (commit_evt),
    .abort_evt  (abort_evt),
    .reject_evt (reject_evt),
    .data_evt   (data_evt),
    .buf_clear  (buf_clear),
    .slot       (slot),
    .word_addr  (word_addr)
  );

  eepw_pagebuf #(
    .PAGE   (PAGE_BYTES),
    .SLOT_W (SLOT_W)
  ) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (buf_clear),
    .wr_en    (data_evt),
    .wr_slot  (slot),
    .wr_data  (byte_data),
    .buf_flat (buf_flat),
    .mask     (buf_mask)
  );

  eepw_wtimer #(
    .TWC (TWC_CYCLES)
  ) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .start (commit_evt),
    .busy  (busy),
    .done  (done_evt)
  );

  eepw_array #(
    .DEPTH  (MEM_DEPTH),
    .PAGE   (PAGE_BYTES),
    .SLOT_W (SLOT_W)
  ) u_arr (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (done_evt),
    .page_addr (word_addr),
    .buf_flat  (buf_flat),
    .mask      (buf_mask),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        wel_q <= 1'b0;
    else if (wel_set)  wel_q <= 1'b1;
    else if (done_evt) wel_q <= 1'b0;
  end

  assign wel = wel_q;

endmodule

// File: rtl/eepw_checks.sv
module eepw_checks #(
  parameter int unsigned TWC  = 20,
  parameter int unsigned PAGE = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            wel,
  input logic            commit_evt,
  input logic            abort_evt,
  input logic            reject_evt,
  input logic            done_evt,
  input logic [PAGE-1:0] mask,
  input logic [15:0]     word_addr
);

  int unsigned run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) run_cnt <= 0;
    else                 run_cnt <= run_cnt + 1;
  end

  // R6: busy lasts exactly TWC cycles
  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_cnt == TWC);

  // R6: completion only inside a write cycle
  p_done_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> busy);

  // R3: a write cycle starts only with the latch armed
  p_arm_needed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wel);

  // R12: latch is clear once the cycle ends
  p_wel_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);

  // R8: a commit always has at least one buffered byte
  p_commit_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> (mask != '0));

  // R9: an abort never starts a write cycle
  p_abort_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !busy);

  // R10: a rejected byte never starts a write cycle
  p_reject_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |=> !busy);

  // R11: no abort or new commit while busy
  p_busy_ignores_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !abort_evt && !commit_evt);

  // R7: target page and buffer mask frozen during the cycle
  p_page_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(word_addr) && $stable(mask));

endmodule

bind eepw_pgwr_ctrl eepw_checks #(
  .TWC  (TWC_CYCLES),
  .PAGE (PAGE_BYTES)
) u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .wel        (wel),
  .commit_evt (commit_evt),
  .abort_evt  (abort_evt),
  .reject_evt (reject_evt),
  .done_evt   (done_evt),
  .mask       (buf_mask),
  .word_addr  (word_addr)
);

// File: tb/test_eepw_pgwr_ctrl.sv
`timescale 1ns/1ps
module test_eepw_pgwr_ctrl;

  localparam logic [7:0] DEV = 8'hA1;
  localparam int TWC   = 12;
  localparam int PAGE  = 16;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        byte_mak = 1'b1;
  logic        standby = 1'b0;
  logic [15:0] rd_addr = '0;
  logic [7:0]  rd_data;
  logic        busy, wel;

  eepw_pgwr_ctrl #(
    .DEV_ADDR   (DEV),
    .PAGE_BYTES (PAGE),
    .MEM_DEPTH  (DEPTH),
    .TWC_CYCLES (TWC)
  ) i_eepw_pgwr_ctrl (
    .clk (clk), .rst_n (rst_n), .byte_vld (byte_vld), .byte_data (byte_data),
    .byte_mak (byte_mak), .standby (standby), .rd_addr (rd_addr),
    .rd_data (rd_data), .busy (busy), .wel (wel)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  n_chk = 0, n_fail = 0;
  bit  ended = 0;
  logic [7:0] exp_mem [DEPTH];
  bit  exp_wel = 0;

  typedef struct { int addr; int data; string tag; } item_t;
  item_t sb_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // monitor: pops expected array bytes and compares against the read port
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        rd_addr = 16'(it.addr);
        #2;
        chk(rd_data == it.data[7:0], it.tag, rd_data, it.data);
      end
    end
  end

  task automatic expect_array(input string tag);
    for (int a = 0; a < DEPTH; a++) sb_q.push_back('{a, exp_mem[a], tag});
    while (sb_q.size() > 0) @(negedge clk);
    #5;
  endtask

  task automatic send_byte(input logic [7:0] d, input logic mak);
    @(negedge clk);
    byte_vld = 1'b1; byte_data = d; byte_mak = mak;
    @(negedge clk);
    byte_vld = 1'b0; byte_mak = 1'b1;
  endtask

  task automatic pulse_standby();
    @(negedge clk); standby = 1'b1;
    @(negedge clk); standby = 1'b0;
  endtask

  task automatic do_wren(input logic [7:0] dev);
    send_byte(8'h55, 1'b1);
    send_byte(dev, 1'b1);
    send_byte(8'h96, 1'b0);
    if (dev == DEV) exp_wel = 1;
  endtask

  task automatic do_write(input logic [7:0] hi, input logic [7:0] lo, input int n,
                          input logic [7:0] base, input bit inject, input string tag);
    logic [7:0] pb [PAGE];
    bit         pv [PAGE];
    int         start, len, slot;
    logic [15:0] wa;
    for (int s = 0; s < PAGE; s++) begin pb[s] = '0; pv[s] = 0; end
    wa = {hi, lo};
    send_byte(8'h55, 1'b1);
    send_byte(DEV, 1'b1);
    send_byte(8'h6C, 1'b1);
    send_byte(hi, 1'b1);
    send_byte(lo, 1'b1);
    for (int j = 0; j < n; j++) begin
      send_byte(base + 8'(j), j != n - 1);
      slot = (int'(lo) + j) % PAGE;
      pb[slot] = base + 8'(j);
      pv[slot] = 1;
    end
    start = cyc;
    chk(busy == exp_wel, {tag, " busy after last byte (R6/R3)"}, busy, exp_wel);
    if (inject) begin
      // R11: a write-enable command and a standby pulse during the cycle
      send_byte(8'h55, 1'b1);
      send_byte(DEV, 1'b1);
      send_byte(8'h96, 1'b0);
      pulse_standby();
    end
    while (busy) @(negedge clk);
    len = cyc - start;
    if (exp_wel) begin
      chk(len == TWC, {tag, " busy length R6"}, len, TWC);
      for (int s = 0; s < PAGE; s++)
        if (pv[s]) exp_mem[(int'(wa & 16'hFFF0) + s) % DEPTH] = pb[s];
      exp_wel = 0;
    end else begin
      chk(len == 0, {tag, " no write cycle R3"}, len, 0);
    end
    chk(wel == exp_wel, {tag, " latch after write R12"}, wel, exp_wel);
    expect_array(tag);
  endtask

  initial begin
    #(64'd200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) exp_mem[a] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(wel == 1'b0, "R1 wel", wel, 0);
    expect_array("R1 array zero");

    // R3 write without enable latch
    do_write(8'h00, 8'h05, 2, 8'h21, 0, "R3 unarmed");
    pulse_standby();

    // R2 write enable
    do_wren(DEV);
    chk(wel == 1'b1, "R2 wel set", wel, 1);

    // R4 / R7 plain three-byte write
    do_write(8'h00, 8'h12, 3, 8'hA0, 0, "R4 R7 basic");

    // R5 wrap at page end
    do_wren(DEV);
    do_write(8'h00, 8'h3C, 6, 8'h30, 0, "R5 wrap");

    // R5 overrun overwrites buffered slots
    do_wren(DEV);
    do_write(8'h00, 8'h20, 20, 8'h80, 0, "R5 overwrite");

    // R8 early no-acknowledge on address low byte
    do_wren(DEV);
    send_byte(8'h55, 1'b1); send_byte(DEV, 1'b1); send_byte(8'h6C, 1'b1);
    send_byte(8'h00, 1'b1); send_byte(8'h08, 1'b0);
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R8 no cycle", busy, 0);
    chk(wel == 1'b1, "R8 latch kept", wel, 1);
    expect_array("R8 array unchanged");

    // R9 standby in the data phase
    send_byte(8'h55, 1'b1); send_byte(DEV, 1'b1); send_byte(8'h6C, 1'b1);
    send_byte(8'h00, 1'b1); send_byte(8'h08, 1'b1);
    send_byte(8'h11, 1'b1); send_byte(8'h12, 1'b1);
    pulse_standby();
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R9 no cycle", busy, 0);
    expect_array("R9 array unchanged");
    // R9 buffered slot 9 must not leak into the next write
    do_write(8'h00, 8'h08, 1, 8'h70, 0, "R9 discard");

    // R10 / R13 wrong device (bit 0 only), header, command
    do_wren(DEV);
    send_byte(8'h55, 1'b1); send_byte(8'hA0, 1'b1); send_byte(8'h6C, 1'b1);
    send_byte(8'h00, 1'b1); send_byte(8'h18, 1'b1); send_byte(8'h99, 1'b0);
    pulse_standby();
    chk(busy == 1'b0, "R13 wrong device no cycle", busy, 0);
    send_byte(8'h54, 1'b1); send_byte(DEV, 1'b1); send_byte(8'h6C, 1'b1);
    send_byte(8'h00, 1'b1); send_byte(8'h19, 1'b1); send_byte(8'h9A, 1'b0);
    pulse_standby();
    chk(busy == 1'b0, "R10 wrong header no cycle", busy, 0);
    send_byte(8'h55, 1'b1); send_byte(DEV, 1'b1); send_byte(8'h03, 1'b1);
    send_byte(8'h00, 1'b1); send_byte(8'h1A, 1'b1); send_byte(8'h9B, 1'b0);
    pulse_standby();
    chk(busy == 1'b0, "R10 wrong command no cycle", busy, 0);
    chk(wel == 1'b1, "R10 latch kept", wel, 1);
    expect_array("R10 array unchanged");

    // R4 high word address aliases modulo depth
    do_write(8'h12, 8'h05, 2, 8'h61, 0, "R4 alias");

    // R11 bytes and standby during busy ignored
    do_wren(DEV);
    do_write(8'h00, 8'h34, 2, 8'h41, 1, "R11 busy ignore");

    finish_run();
  end

endmodule